// File: doc/BRIEF.md
# Timer Input Edge Qualifier

This block conditions two external pins for a timer: an event-count pin and a trigger pin. Each pin goes through a two-flop synchronizer, and the block compares the synchronized level with its value one clock earlier. A 2-bit selection field per pin picks which transitions count. A qualifying transition produces a pulse exactly one clock wide. Event pulses drive an external event counter. Trigger pulses drive a trigger or capture path.

An 8-bit control register holds both selection fields. A simple register bus can write it as a whole byte or one bit at a time, and can read it back. While the timer runs, a write that would alter a field is refused and a sticky error flag is raised; a write that leaves the fields unchanged is still accepted. Event pulses appear only when the external-event enable is set or the timer mode input selects event counting.

Top module: `tmr_edge_cond`

## Requirements
- R1: After reset, the register reads 0x00, the error flag is 0 and neither pulse output is active.
- R2: The event selection sits in register bits 3:2 and the trigger selection in bits 1:0. Read data bits 7:4 are always 0, and write data in bits 7:4 is discarded.
- R3: With the timer enable low, a byte write (bus_bit_i=0) loads write data bits 3:0 into the register on the clock edge where bus_we_i is high.
- R4: A bit write (bus_bit_i=1) copies bus_wdata_i[0] into the register bit addressed by bus_bitsel_i and leaves the other bits as they were. An address of 4 to 7 has no effect.
- R5: The selection encoding is 00 = none, 01 = rising, 10 = falling, 11 = both. Each qualifying pin transition gives exactly one pulse, one clock wide. The pulse is high in the cycle after the second rising clock edge that samples the new pin level.
- R6: The trigger pulse follows the trigger selection whatever the state of the event gating inputs.
- R7: An event pulse is produced only when ext_evt_en_i is 1 or mode_i equals 3'b001. Otherwise event transitions are dropped.
- R8: While tmr_en_i is 1, a write whose resulting fields differ from the stored ones leaves the register unchanged and sets err_o. err_o then stays set until reset.
- R9: While tmr_en_i is 1, a write whose resulting fields equal the stored ones is accepted and does not set err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe |
| bus_bit_i | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_bitsel_i | input | 3 | Bit index for a single-bit write |
| bus_wdata_i | input | 8 | Write data (bit 0 carries the value of a single-bit write) |
| bus_rdata_o | output | 8 | Register read data |
| tmr_en_i | input | 1 | Timer running; locks the edge fields |
| ext_evt_en_i | input | 1 | External-event enable |
| mode_i | input | 3 | Timer mode; 3'b001 is event counting |
| evt_pin_i | input | 1 | Asynchronous event-count pin |
| trg_pin_i | input | 1 | Asynchronous trigger pin |
| evt_pulse_o | output | 1 | One-cycle pulse for each qualified event edge |
| trg_pulse_o | output | 1 | One-cycle pulse for each qualified trigger edge |
| err_o | output | 1 | Sticky flag for a refused write |

## Verification
Two things can happen in the same clock: a write that the lock refuses, and a pin transition passing through edge detection. The bench raises the trigger pin in the same cycle as a refused write that would switch the trigger field from rising to falling. It expects one trigger pulse under the old selection, an unchanged read-back and err_o set. A second collision drives both pins in the same cycle and expects both pulse outputs high together for one cycle.

// File: rtl/tec_pkg.sv
package tec_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned FIELD_W   = 2;
  localparam int unsigned NUM_CH    = 2;
  localparam int unsigned USED_W    = FIELD_W * NUM_CH;
  localparam int unsigned CH_TRG    = 0;  // bits 1:0
  localparam int unsigned CH_EVT    = 1;  // bits 3:2
  localparam logic [2:0]  MODE_EVCNT = 3'b001;
endpackage

// File: rtl/tec_sync.sv
module tec_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tec_edge_det.sv
module tec_edge_det
  import tec_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      pulse_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: pulse_o = rise;
      EDGE_FALL: pulse_o = fall;
      EDGE_BOTH: pulse_o = rise | fall;
      default:   pulse_o = 1'b0;
    endcase
  end

  AST_NONE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_NONE) |-> !pulse_o); // R5
  AST_RISE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_RISE && pulse_o) |-> lvl_i); // R5
  AST_FALL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_FALL && pulse_o) |-> !lvl_i); // R5
endmodule

// File: rtl/tec_ctl_reg.sv
module tec_ctl_reg
  import tec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              bit_i,
  input  logic [2:0]        bitsel_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              lock_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [USED_W-1:0] fields_o,
  output logic              err_o
);
  logic [USED_W-1:0] ctl_q;
  logic [REG_W-1:0]  merged;
  logic [USED_W-1:0] wr_val;
  logic              blocked;
  logic              err_q;

  always_comb begin
    merged = {{(REG_W-USED_W){1'b0}}, ctl_q};
    if (bit_i) merged[bitsel_i] = wdata_i[0];
    else       merged = wdata_i;
    wr_val = merged[USED_W-1:0];
  end

  // same-value writes pass the lock
  assign blocked = we_i & lock_i & (wr_val != ctl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (we_i && !blocked) ctl_q <= wr_val;
      if (blocked)          err_q <= 1'b1;
    end
  end

  assign rdata_o  = {{(REG_W-USED_W){1'b0}}, ctl_q};
  assign fields_o = ctl_q;
  assign err_o    = err_q;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(ctl_q)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_q)); // R3
  AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:USED_W] == '0); // R2
endmodule

// File: rtl/tmr_edge_cond.sv
module tmr_edge_cond
  import tec_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_we_i,
  input  logic       bus_bit_i,
  input  logic [2:0] bus_bitsel_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  input  logic       tmr_en_i,
  input  logic       ext_evt_en_i,
  input  logic [2:0] mode_i,
  input  logic       evt_pin_i,
  input  logic       trg_pin_i,
  output logic       evt_pulse_o,
  output logic       trg_pulse_o,
  output logic       err_o
);
  logic [USED_W-1:0] fields;
  logic [NUM_CH-1:0] pins, lvl, det;
  logic              evt_gate;

  tec_ctl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .bit_i    (bus_bit_i),
    .bitsel_i (bus_bitsel_i),
    .wdata_i  (bus_wdata_i),
    .lock_i   (tmr_en_i),
    .rdata_o  (bus_rdata_o),
    .fields_o (fields),
    .err_o    (err_o)
  );

  assign pins[CH_TRG] = trg_pin_i;
  assign pins[CH_EVT] = evt_pin_i;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (pins[c]),
        .q_o   (lvl[c])
      );
      tec_edge_det u_det (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl[c]),
        .sel_i  (edge_sel_e'(fields[c*FIELD_W +: FIELD_W])),
        .pulse_o(det[c])
      );
    end
  endgenerate

  assign evt_gate    = ext_evt_en_i | (mode_i == MODE_EVCNT);
  assign evt_pulse_o = det[CH_EVT] & evt_gate;
  assign trg_pulse_o = det[CH_TRG];

  AST_EVT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_pulse_o |-> (ext_evt_en_i || mode_i == 3'b001)); // R7
  AST_EVT_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_pulse_o |-> (bus_rdata_o[3:2] != 2'b00)); // R2
  AST_TRG_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_pulse_o |-> (bus_rdata_o[1:0] != 2'b00)); // R6
endmodule

// File: tb/tmr_edge_cond_tb.sv
module tmr_edge_cond_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_we_i = 1'b0, bus_bit_i = 1'b0;
  logic [2:0] bus_bitsel_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       tmr_en_i = 1'b0, ext_evt_en_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic       evt_pin_i = 1'b0, trg_pin_i = 1'b0;
  logic       evt_pulse_o, trg_pulse_o, err_o;

  int checks = 0, failures = 0;
  int n_evt, n_trg, n_both;

  always #4 clk_i = ~clk_i;  // 125 MHz

  tmr_edge_cond u_dut (.*);

  // {sel[1:0], level, ext_en, mode[2:0], exp_evt}
  localparam int NV = 9;
  localparam logic [7:0] VEC [NV] = '{
    {2'b01, 1'b1, 1'b1, 3'b000, 1'b1},
    {2'b01, 1'b0, 1'b1, 3'b000, 1'b0},
    {2'b10, 1'b1, 1'b1, 3'b000, 1'b0},
    {2'b10, 1'b0, 1'b1, 3'b000, 1'b1},
    {2'b11, 1'b1, 1'b0, 3'b001, 1'b1},
    {2'b11, 1'b0, 1'b0, 3'b001, 1'b1},
    {2'b11, 1'b1, 1'b0, 3'b010, 1'b0},
    {2'b00, 1'b0, 1'b1, 3'b001, 1'b0},
    {2'b11, 1'b1, 1'b0, 3'b000, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic bitm, input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_bit_i = bitm; bus_bitsel_i = sel; bus_wdata_i = d;
    @(negedge clk_i);
    bus_we_i = 1'b0; bus_bit_i = 1'b0;
  endtask

  task automatic count(input int cyc);
    n_evt = 0; n_trg = 0; n_both = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      n_evt += int'(evt_pulse_o);
      n_trg += int'(trg_pulse_o);
      n_both += int'(evt_pulse_o & trg_pulse_o);
    end
  endtask

  initial begin
    #2_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", bus_rdata_o, 8'h00);
    chk("R1 err", {7'b0, err_o}, 8'h00);
    chk("R1 pulses", {6'b0, evt_pulse_o, trg_pulse_o}, 8'h00);
    rst_ni = 1'b1;

    // R5 R7 vector table
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, 3'd0, {4'h0, VEC[v][7:6], 2'b00});
      ext_evt_en_i = VEC[v][4];
      mode_i = VEC[v][3:1];
      evt_pin_i = VEC[v][5];
      // new level sampled at next edge, pulse after the second edge
      @(negedge clk_i); @(negedge clk_i);
      chk("R5 latency", {7'b0, evt_pulse_o}, {7'b0, VEC[v][0]});
      count(4);
      chk("R5 R7 evt count", 8'(n_evt), 8'(0));
      chk("R6 trg quiet", 8'(n_trg), 8'(0));
    end
    ext_evt_en_i = 1'b0; mode_i = 3'b000;
    evt_pin_i = 1'b0;
    count(4);

    // R6 trigger ignores event gating
    wr(1'b0, 3'd0, 8'h01);
    trg_pin_i = 1'b1; count(5);
    chk("R6 trg rise", 8'(n_trg), 8'd1);
    wr(1'b0, 3'd0, 8'h03);
    trg_pin_i = 1'b0; count(5);
    chk("R6 trg both fall", 8'(n_trg), 8'd1);
    chk("R7 evt gated", 8'(n_evt), 8'd0);

    // R2 R3 byte write, upper bits dropped
    wr(1'b0, 3'd0, 8'hFF);
    chk("R2 R3 byte", bus_rdata_o, 8'h0F);
    wr(1'b0, 3'd0, 8'h00);
    // R4 bit writes
    wr(1'b1, 3'd2, 8'h01);
    chk("R4 bit2 set", bus_rdata_o, 8'h04);
    wr(1'b1, 3'd6, 8'h01);
    chk("R4 upper bit", bus_rdata_o, 8'h04);
    wr(1'b1, 3'd0, 8'hFF);
    chk("R4 bit0 set", bus_rdata_o, 8'h05);
    wr(1'b1, 3'd2, 8'hFE);
    chk("R4 bit2 clr", bus_rdata_o, 8'h01);

    // R9 same-value writes under lock
    tmr_en_i = 1'b1;
    wr(1'b0, 3'd0, 8'hF1);
    chk("R9 byte same", bus_rdata_o, 8'h01);
    wr(1'b1, 3'd0, 8'h01);
    chk("R9 bit same", bus_rdata_o, 8'h01);
    chk("R9 no err", {7'b0, err_o}, 8'h00);

    // R8 refused write colliding with a trigger edge
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_bit_i = 1'b0; bus_wdata_i = 8'h02;
    trg_pin_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
    chk("R8 unchanged", bus_rdata_o, 8'h01);
    chk("R8 err set", {7'b0, err_o}, 8'h01);
    count(4);
    chk("R8 R5 old sel pulse", 8'(n_trg), 8'd1);
    wr(1'b1, 3'd3, 8'h01);
    chk("R8 bit refused", bus_rdata_o, 8'h01);

    // R8 sticky after unlock, then rewrite allowed
    tmr_en_i = 1'b0;
    wr(1'b0, 3'd0, 8'h0F);
    chk("R3 unlock write", bus_rdata_o, 8'h0F);
    chk("R8 sticky", {7'b0, err_o}, 8'h01);

    // R5 R6 R7 both pins switch together
    ext_evt_en_i = 1'b1;
    @(negedge clk_i);
    evt_pin_i = 1'b1; trg_pin_i = 1'b0;
    count(5);
    chk("R5 both evt", 8'(n_evt), 8'd1);
    chk("R6 both trg", 8'(n_trg), 8'd1);
    chk("R7 coincident", 8'(n_both), 8'd1);

    // R1 reset clears
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 rst rdata", bus_rdata_o, 8'h00);
    chk("R1 rst err", {7'b0, err_o}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule